// File: doc/BRIEF.md
# I2C Master Bit Engine

This block drives a two-wire I2C bus as the only master on it. A controller issues one command at a time through a small valid/opcode interface. The engine expands each command into a fixed series of bus phases: a START, a STOP, a byte written out, a byte read in, or a recovery burst that clocks a confused slave back to idle. Both bus lines are open-drain. The engine only ever pulls a line low or lets it go, and the pads are modelled as separate pull-low enables plus a sampled data input.

Every phase lasts `half_div + 1` system clocks, so a whole SCL period is twice that. While a command runs, `busy` is high. When the command completes, `done` pulses for a single clock, and from then on `rx_data` (read) and `rx_nack` (write) hold the result. A byte transfer leaves SCL pulled low and SDA released, so the next command can be a repeated START, another byte or a STOP.

Top module: `i2cm_engine`

## Requirements
- R1: After synchronous reset, `busy`, `done`, `scl_oe` and `sda_oe` are all 0, so both lines are released.
- R2: A command is accepted only when `cmd_valid` is high, `busy` is low and `cmd_op` is 0 to 4. `cmd_valid` during a running command, or with a code from 5 to 7, is ignored: it starts nothing and changes no pin.
- R3: `done` is high for exactly one clock per command, and in that same cycle `busy` has just fallen.
- R4: Every phase holds its pin levels for `half_div + 1` clocks. Measured in phases, `busy` stays high for 4 (START), 3 (STOP), 19 (write byte, read byte) or 21 (recovery).
- R5: START (code 1) releases SCL with SDA released, then pulls SDA low while SCL is released, then pulls SCL low. It works from idle and as a repeated START.
- R6: STOP (code 2) pulls SDA low while SCL is low, releases SCL, then releases SDA while SCL is released. Both lines end released.
- R7: Write byte (code 3) presents `cmd_wdata` most significant bit first, one bit per SCL pulse. During the command SDA changes only while SCL is pulled low, so the byte produces no START or STOP.
- R8: On the ninth SCL pulse of a write, the engine releases SDA and samples it at the end of the high phase. `rx_nack` returns that level: 0 means acknowledged, 1 means not acknowledged.
- R9: Read byte (code 4) releases SDA for eight pulses and samples each one at the end of its high phase. The bits go into `rx_data` most significant first.
- R10: On the ninth pulse of a read, the engine pulls SDA low when `cmd_ack_lvl` is 0 (acknowledge) and releases it when `cmd_ack_lvl` is 1 (not-acknowledge).
- R11: Recovery (code 0) gives nine SCL pulses with SDA released and then a STOP. The STOP's own rise of SCL is a tenth rise, with SDA low, and both lines end released.
- R12: After a write or read byte, SCL is left pulled low and SDA released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| half_div | input | DIV_W | Phase length minus one, in system clocks |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 3 | 0 recover, 1 START, 2 STOP, 3 write byte, 4 read byte |
| cmd_wdata | input | 8 | Byte to write |
| cmd_ack_lvl | input | 1 | Level for the ninth pulse of a read: 0 acknowledge, 1 not-acknowledge |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-clock completion pulse |
| rx_data | output | 8 | Byte received by the last read |
| rx_nack | output | 1 | Acknowledge level sampled by the last write |
| scl_oe | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| sda_i | input | 1 | Sampled SDA line level |

## Verification
The phase-length assertion assumes that `half_div` is held steady while a command is running. The bench changes the divider only between commands, while the engine is idle. Nothing watches SCL, so both the assertions and the scoreboard assume that no slave stretches the clock. The modelled slave changes SDA only in the half-cycle after it sees SCL fall, so every value the engine samples has settled through a full low phase. The bench sweeps all 256 write and read bytes at two divider settings, alternating acknowledge and not-acknowledge.

// File: rtl/i2cm_pkg.sv
// Package: i2cm_pkg
// Shared opcodes, pin-state type and per-phase pin decode for the I2C
// master bit engine. Assumes an 8-bit byte and a nine-pulse recovery burst.
package i2cm_pkg;

    localparam int STEP_W     = 5;
    localparam int BYTE_BITS  = 8;
    localparam int RCV_PULSES = 9;

    typedef enum logic [2:0] {
        OP_RECOVER = 3'd0,
        OP_START   = 3'd1,
        OP_STOP    = 3'd2,
        OP_WRITE   = 3'd3,
        OP_READ    = 3'd4
    } i2cm_op_e;

    typedef struct packed {
        logic scl_low;
        logic sda_low;
    } i2cm_pins_t;

    // Step index of the trailing SCL-low phase of a byte op.
    localparam logic [STEP_W-1:0] BYTE_TAIL = STEP_W'(2 * (BYTE_BITS + 1));
    // Step index of the ninth (acknowledge) high phase.
    localparam logic [STEP_W-1:0] ACK_HIGH  = STEP_W'(2 * BYTE_BITS + 1);
    // First step of the STOP that closes a recovery burst.
    localparam logic [STEP_W-1:0] RCV_STOP  = STEP_W'(2 * RCV_PULSES);

    // Index of the final step of each command.
    function automatic logic [STEP_W-1:0] last_step(i2cm_op_e op);
        case (op)
            OP_START:   return STEP_W'(3);
            OP_STOP:    return STEP_W'(2);
            OP_RECOVER: return RCV_STOP + STEP_W'(2);
            default:    return BYTE_TAIL;
        endcase
    endfunction

    // Pin levels for step s of a command; msb is the current write bit.
    function automatic i2cm_pins_t step_pins(i2cm_op_e op, logic [STEP_W-1:0] s,
                                             logic msb, logic ack_lvl);
        i2cm_pins_t p;
        logic [STEP_W-1:0] k;
        p = '0;
        k = s >> 1;
        case (op)
            OP_START: begin
                p.scl_low = (s == STEP_W'(0)) || (s == STEP_W'(3));
                p.sda_low = (s >= STEP_W'(2));
            end
            OP_STOP: begin
                p.scl_low = (s == STEP_W'(0));
                p.sda_low = (s <= STEP_W'(1));
            end
            OP_RECOVER: begin
                if (s < RCV_STOP) begin
                    p.scl_low = ~s[0];
                    p.sda_low = 1'b0;
                end else begin
                    p.scl_low = (s == RCV_STOP);
                    p.sda_low = (s <= RCV_STOP + STEP_W'(1));
                end
            end
            default: begin
                if (s >= BYTE_TAIL) begin
                    p.scl_low = 1'b1;
                    p.sda_low = 1'b0;
                end else begin
                    p.scl_low = ~s[0];
                    if (k < STEP_W'(BYTE_BITS))
                        p.sda_low = (op == OP_WRITE) ? ~msb : 1'b0;
                    else
                        p.sda_low = (op == OP_READ) ? ~ack_lvl : 1'b0;
                end
            end
        endcase
        return p;
    endfunction

endpackage

// File: rtl/i2cm_phase_timer.sv
// Module: i2cm_phase_timer
// Counts system clocks inside one bus phase and flags the last clock.
// Assumes div is stable while run is high; idles at zero otherwise.
module i2cm_phase_timer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             last
);

    logic [DIV_W-1:0] cnt_q;

    assign last = (cnt_q == div);

    // Advance within a phase, wrap at the phase end, hold zero when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || last)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

endmodule

// File: rtl/i2cm_shifter.sv
// Module: i2cm_shifter
// Byte shift register shared by write and read, plus the acknowledge
// capture flop. Shifts left, inserting the sampled line at bit 0.
module i2cm_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    input  logic         bit_in,
    input  logic         ack_cap,
    output logic [W-1:0] data,
    output logic         ack,
    output logic         msb_next
);

    logic [W-1:0] data_q;
    logic         ack_q;

    assign data     = data_q;
    assign ack      = ack_q;
    assign msb_next = shift ? data_q[W-2] : data_q[W-1];

    // Load a new byte or shift in one sampled bit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            data_q <= '0;
        else if (load)
            data_q <= load_val;
        else if (shift)
            data_q <= {data_q[W-2:0], bit_in};
    end

    // Capture the ninth-pulse level of a write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ack_q <= 1'b0;
        else if (ack_cap)
            ack_q <= bit_in;
    end

endmodule

// File: rtl/i2cm_engine.sv
// Module: i2cm_engine (top)
// Single-master I2C bit engine. It accepts one command while idle, steps
// through that command's phases, each half_div+1 clocks long, and drives
// open-drain enables from registers. It assumes no clock stretching and a
// half_div that is stable during a command.
module i2cm_engine
    import i2cm_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] half_div,
    input  logic             cmd_valid,
    input  logic [2:0]       cmd_op,
    input  logic [7:0]       cmd_wdata,
    input  logic             cmd_ack_lvl,
    output logic             busy,
    output logic             done,
    output logic [7:0]       rx_data,
    output logic             rx_nack,
    output logic             scl_oe,
    output logic             sda_oe,
    input  logic             sda_i
);

    i2cm_op_e          op_q;
    logic [STEP_W-1:0] step_q;
    logic              busy_q, done_q, ack_lvl_q;
    i2cm_pins_t        pins_q;

    logic accept, step_end, final_step, is_byte;
    logic shift_en, ack_cap, msb_next, tmr_last;

    assign accept     = cmd_valid && !busy_q && (cmd_op <= OP_READ);
    assign step_end   = busy_q && tmr_last;
    assign final_step = (step_q == last_step(op_q));
    assign is_byte    = (op_q == OP_WRITE) || (op_q == OP_READ);
    assign shift_en   = step_end && is_byte && step_q[0] &&
                        (step_q < STEP_W'(2 * BYTE_BITS));
    assign ack_cap    = step_end && is_byte && (step_q == ACK_HIGH);

    i2cm_phase_timer #(.DIV_W(DIV_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy_q),
        .div   (half_div),
        .last  (tmr_last)
    );

    i2cm_shifter #(.W(BYTE_BITS)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_val (cmd_wdata),
        .shift    (shift_en),
        .bit_in   (sda_i),
        .ack_cap  (ack_cap),
        .data     (rx_data),
        .ack      (rx_nack),
        .msb_next (msb_next)
    );

    // Command sequencer: accept, step through phases, pulse done at the end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q    <= 1'b0;
            done_q    <= 1'b0;
            op_q      <= OP_START;
            step_q    <= '0;
            ack_lvl_q <= 1'b1;
            pins_q    <= '0;
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                busy_q    <= 1'b1;
                op_q      <= i2cm_op_e'(cmd_op);
                step_q    <= '0;
                ack_lvl_q <= cmd_ack_lvl;
                pins_q    <= step_pins(i2cm_op_e'(cmd_op), '0, cmd_wdata[7], cmd_ack_lvl);
            end else if (step_end) begin
                if (final_step) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end else begin
                    step_q <= step_q + 1'b1;
                    pins_q <= step_pins(op_q, step_q + 1'b1, msb_next, ack_lvl_q);
                end
            end
        end
    end

    assign busy   = busy_q;
    assign done   = done_q;
    assign scl_oe = pins_q.scl_low;
    assign sda_oe = pins_q.sda_low;

endmodule

// File: rtl/i2cm_checker.sv
// Module: i2cm_checker
// Protocol checks on the engine's ports and its active opcode. It assumes
// half_div is stable while busy. It is bound into every i2cm_engine instance.
module i2cm_checker #(
    parameter int DIV_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [DIV_W-1:0] half_div,
    input logic             cmd_valid,
    input logic [2:0]       cmd_op,
    input logic             busy,
    input logic             done,
    input logic             scl_oe,
    input logic             sda_oe,
    input logic [2:0]       op_q
);

    logic             prev_scl, prev_sda, prev_busy, moved;
    logic [DIV_W:0]   run_len;

    assign moved = (scl_oe != prev_scl) || (sda_oe != prev_sda);

    // Remember last cycle's pins and busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_scl  <= 1'b0;
            prev_sda  <= 1'b0;
            prev_busy <= 1'b0;
        end else begin
            prev_scl  <= scl_oe;
            prev_sda  <= sda_oe;
            prev_busy <= busy;
        end
    end

    // Length of the current unchanged pin run, restarted on a new command.
    always_ff @(posedge clk) begin
        if (!rst_n || moved || (busy && !prev_busy))
            run_len <= '0;
        else if (run_len != '1)
            run_len <= run_len + 1'b1;
    end

    p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_ends_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_valid && (cmd_op <= 3'd4)) |=> busy);

    p_ignore_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_valid && (cmd_op > 3'd4)) |=> !busy);

    p_phase_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && prev_busy && moved) |-> (run_len == {1'b0, half_div}));

    p_sda_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ((op_q == 3'd3) || (op_q == 3'd4)) && !scl_oe && !prev_scl)
            |-> (sda_oe == prev_sda));

endmodule

bind i2cm_engine i2cm_checker #(.DIV_W(DIV_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .half_div  (half_div),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .busy      (busy),
    .done      (done),
    .scl_oe    (scl_oe),
    .sda_oe    (sda_oe),
    .op_q      (op_q)
);

// File: tb/tb_i2cm_engine.sv
`timescale 1ns/1ps
module tb_i2cm_engine;
    import i2cm_pkg::*;

    localparam int DIV_W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic [DIV_W-1:0] half_div = '0;
    logic             cmd_valid = 1'b0;
    logic [2:0]       cmd_op = 3'd0;
    logic [7:0]       cmd_wdata = 8'h00;
    logic             cmd_ack_lvl = 1'b1;
    logic             busy, done, rx_nack, scl_oe, sda_oe, sda_i;
    logic [7:0]       rx_data;
    logic             slv_pull;

    assign sda_i = ~(sda_oe | slv_pull);

    i2cm_engine #(.DIV_W(DIV_W)) dut (
        .clk(clk), .rst_n(rst_n), .half_div(half_div), .cmd_valid(cmd_valid),
        .cmd_op(cmd_op), .cmd_wdata(cmd_wdata), .cmd_ack_lvl(cmd_ack_lvl),
        .busy(busy), .done(done), .rx_data(rx_data), .rx_nack(rx_nack),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_i(sda_i)
    );

    int n_chk = 0, n_bad = 0;
    int rises = 0, falls = 0, starts = 0, stops = 0;
    int rb = 0, fb = 0, sb = 0, pb = 0;
    logic [15:0] bitlog = '0;
    logic [8:0]  slv_plan = '0;
    logic        prev_scl_l = 1'b1, prev_sda_l = 1'b1;

    // Slave model: its next bit is presented after each SCL fall (plan bit 1 = pull low).
    always_comb begin
        int fl;
        fl = falls - fb;
        slv_pull = (fl < 9) ? slv_plan[8 - fl] : 1'b0;
    end

    // Bus monitor, sampled away from the active edge.
    always @(negedge clk) begin
        logic scl_l, sda_l;
        scl_l = ~scl_oe;
        sda_l = sda_i;
        if (scl_l && !prev_scl_l) begin
            rises  = rises + 1;
            bitlog = {bitlog[14:0], sda_l};
        end
        if (!scl_l && prev_scl_l) falls = falls + 1;
        if (scl_l && prev_scl_l && prev_sda_l && !sda_l) starts = starts + 1;
        if (scl_l && prev_scl_l && !prev_sda_l && sda_l) stops = stops + 1;
        prev_scl_l = scl_l;
        prev_sda_l = sda_l;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Wait for done and count busy cycles, then check the done pulse.
    task automatic wait_done(output int cyc);
        cyc = 0;
        forever begin
            @(negedge clk); #1;
            if (done) break;
            if (busy) cyc++;
            if (cyc > 20000) break;
        end
        chk(done && !busy, "R3 busy low in done cycle", busy, 0);
        @(negedge clk); #1;
        chk(!done, "R3 done lasts one clock", done, 0);
    endtask

    task automatic run_cmd(input logic [2:0] op, input logic [7:0] wd, input logic al,
                           input logic [8:0] plan, output int cyc);
        @(posedge clk); #2;
        rb = rises; fb = falls; sb = starts; pb = stops;
        slv_plan = plan;
        cmd_valid = 1'b1; cmd_op = op; cmd_wdata = wd; cmd_ack_lvl = al;
        @(posedge clk); #2;
        cmd_valid = 1'b0;
        wait_done(cyc);
    endtask

    task automatic do_start(input int dv);
        int cyc;
        run_cmd(OP_START, 8'h00, 1'b1, 9'd0, cyc);
        chk(cyc == 4 * (dv + 1), "R4 START length", cyc, 4 * (dv + 1));
        chk(starts - sb == 1 && stops - pb == 0, "R5 one START seen", starts - sb, 1);
        chk(scl_oe && sda_oe, "R5 lines low after START", {scl_oe, sda_oe}, 3);
    endtask

    task automatic do_stop(input int dv);
        int cyc;
        run_cmd(OP_STOP, 8'h00, 1'b1, 9'd0, cyc);
        chk(cyc == 3 * (dv + 1), "R4 STOP length", cyc, 3 * (dv + 1));
        chk(stops - pb == 1 && starts - sb == 0, "R6 one STOP seen", stops - pb, 1);
        chk(!scl_oe && !sda_oe, "R6 lines released", {scl_oe, sda_oe}, 0);
    endtask

    task automatic do_write(input int dv, input logic [7:0] b, input logic pull);
        int cyc;
        run_cmd(OP_WRITE, b, 1'b1, {8'h00, pull}, cyc);
        chk(cyc == 19 * (dv + 1), "R4 write length", cyc, 19 * (dv + 1));
        chk(rises - rb == 9, "R7 nine pulses", rises - rb, 9);
        chk(bitlog[8:1] == b, "R7 bits MSB first", bitlog[8:1], b);
        chk(starts - sb == 0 && stops - pb == 0, "R7 no START/STOP", starts - sb + stops - pb, 0);
        chk(bitlog[0] == !pull, "R8 ninth level", bitlog[0], !pull);
        chk(rx_nack == !pull, "R8 rx_nack", rx_nack, !pull);
        chk(scl_oe && !sda_oe, "R12 SCL low SDA free", {scl_oe, sda_oe}, 2);
    endtask

    task automatic do_read(input int dv, input logic [7:0] b, input logic al);
        int cyc;
        run_cmd(OP_READ, 8'h00, al, {~b, 1'b0}, cyc);
        chk(cyc == 19 * (dv + 1), "R4 read length", cyc, 19 * (dv + 1));
        chk(rx_data == b, "R9 rx_data", rx_data, b);
        chk(bitlog[8:1] == b, "R9 line bits", bitlog[8:1], b);
        chk(bitlog[0] == al, "R10 ninth level", bitlog[0], al);
        chk(scl_oe && !sda_oe, "R12 SCL low SDA free", {scl_oe, sda_oe}, 2);
    endtask

    task automatic do_recover(input int dv);
        int cyc;
        run_cmd(OP_RECOVER, 8'h00, 1'b1, 9'd0, cyc);
        chk(cyc == 21 * (dv + 1), "R4 recovery length", cyc, 21 * (dv + 1));
        chk(rises - rb == 10, "R11 rise count", rises - rb, 10);
        chk(bitlog[9:0] == 10'b1111111110, "R11 SDA levels", bitlog[9:0], 10'h3FE);
        chk(stops - pb == 1 && starts - sb == 0, "R11 closing STOP", stops - pb, 1);
        chk(!scl_oe && !sda_oe, "R11 lines released", {scl_oe, sda_oe}, 0);
    endtask

    bit finished = 1'b0;

    initial begin
        #1_900_000;
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int cyc;
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        chk(!busy && !done && !scl_oe && !sda_oe, "R1 state in reset",
            {busy, done, scl_oe, sda_oe}, 0);
        @(posedge clk); #2; rst_n = 1'b1;
        @(negedge clk); #1;
        chk(!busy && !done && !scl_oe && !sda_oe, "R1 state after reset",
            {busy, done, scl_oe, sda_oe}, 0);

        for (int d = 0; d <= 2; d += 2) begin
            half_div = DIV_W'(d);
            for (int b = 0; b < 256; b++) begin
                do_start(d);
                do_write(d, 8'(b), b[0]);
                do_read(d, 8'(b) ^ 8'h5A, b[1]);
                do_stop(d);
            end
        end

        half_div = DIV_W'(5);
        for (int b = 0; b < 6; b++) begin
            do_start(5);
            do_write(5, 8'(37 * b + 1), b[0]);
            do_start(5);
            do_read(5, 8'(91 * b + 3), b[0]);
            do_stop(5);
        end

        for (int d = 0; d <= 5; d++) begin
            half_div = DIV_W'(d);
            do_recover(d);
        end

        half_div = DIV_W'(1);
        @(posedge clk); #2;
        pb = stops;
        slv_plan = '0;
        cmd_valid = 1'b1; cmd_op = OP_START;
        @(posedge clk); #2; cmd_op = OP_STOP;
        @(posedge clk); #2;
        @(posedge clk); #2; cmd_valid = 1'b0;
        wait_done(cyc);
        repeat (4) @(negedge clk); #1;
        chk(!busy && scl_oe && sda_oe, "R2 command while busy ignored",
            {busy, scl_oe, sda_oe}, 3);
        chk(stops - pb == 0, "R2 no STOP from ignored command", stops - pb, 0);

        @(posedge clk); #2;
        cmd_valid = 1'b1; cmd_op = 3'd6;
        @(posedge clk); #2; cmd_valid = 1'b0;
        @(negedge clk); #1;
        chk(!busy, "R2 code 6 not accepted", busy, 0);
        repeat (5) @(negedge clk); #1;
        chk(!done && scl_oe && sda_oe, "R2 code 6 no effect", {done, scl_oe, sda_oe}, 3);
        do_stop(1);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule